// File: doc/BRIEF.md
# Self-Checking Reversible Gate Cascade

This block evaluates a fixed cascade of multi-control reversible gates over a set of input lines, a set of output lines and one check line. A parameter table gives the cascade. For each gate it holds a mask of the input lines used as controls, a polarity per control and the output line that the gate targets. A gate fires when all of its selected controls hold their required level. A firing gate inverts its target output line and also the check line. At load, the check line is seeded with the XOR of the applied inputs. After the last gate, the output lines are folded into the check line, and then the input lines are folded in.

At the end of a correct run the check line holds 0. If a single line is flipped anywhere in the cascade, the check line ends at 1. This holds even when the flipped bit has spread through later gates onto several lines. The final check line is reported as the error flag.

The user asserts `start` with an input vector. The cascade then evaluates one gate per clock and spends two cycles folding. A one-cycle `done` pulse marks the point where `outVec` and `errFlag` are valid. A fault-injection port is sampled together with `start`. It flips exactly one chosen line at the beginning of one chosen stage, which lets the detection property be exercised.

Top module: `revCascadeTop`

## Requirements
- R1: After reset, `busy`, `done`, `errFlag` and `outVec` are all 0.
- R2: A run with no injected fault ends with `errFlag` = 0 for every input vector.
- R3: Gate g fires when every input line whose bit is set in its control mask equals its polarity bit (polarity 1 = line must be 1, polarity 0 = line must be 0). A gate with an empty mask always fires. Input lines outside the mask have no effect on the gate. A firing gate inverts output line `TGT[g]` (field of `TW` bits per gate, gate 0 in the lowest bits). At `done`, `outVec` equals the result of applying gates 0..N-1 in order to all-zero outputs.
- R4: Gates never change input lines. Only input lines act as controls.
- R5: `done` rises exactly N+2 clock edges after the edge that samples `start`, lasts one cycle, and `busy` is high from the sampling edge until `done`.
- R6: A `start` while `busy` is high is ignored. The run in progress completes with its original inputs and timing.
- R7: The fault inputs are sampled with `start`. Stage s < N flips the line just before gate s. Stage N flips it after the last gate and before folding. Line index 0..P-1 selects an input line, P..P+Q-1 selects output line index-P, and P+Q selects the check line. Exactly one bit is flipped.
- R8: Any single in-range injected fault ends with `errFlag` = 1. This includes an input-line fault that spreads onto several output lines.
- R9: A fault injected on the check line ends with `errFlag` = 1.
- R10: A stage index above N or a line index above P+Q injects nothing. The results then equal those of a fault-free run.
- R11: `outVec` and `errFlag` hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| inVec | input | P | Input line values |
| faultEn | input | 1 | Enable the single-bit fault for this run |
| faultStage | input | SW | Stage before which the fault is applied (0..N) |
| faultLine | input | LW | Line to flip (inputs, outputs, check line) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse, results valid |
| outVec | output | Q | Output line values |
| errFlag | output | 1 | Final check line value, 1 = fault detected |

## Verification
A wrong bit in the line register cannot stay hidden. Any corrupted line, including the check line itself, shows up as `errFlag` = 1 in the `done` cycle N+2 edges after `start`. A corrupted output line also shows in `outVec` at that point. A wrong stage counter or state shows up as `done` arriving at the wrong edge, or as gates applied out of order. An out-of-order cascade gives an `outVec` that differs from the model for input vectors where the gates interact. The directed tests sweep every input vector, and every stage and line of injection, so each such deviation is visible within one run.

// File: rtl/revCascadePkg.sv
package revCascadePkg;
  typedef struct packed {
    logic load;
    logic gate;
    logic foldOut;
    logic foldIn;
  } strobeT;
endpackage

// File: rtl/revCtrl.sv
module revCtrl #(
  parameter int N_GATES = 4,
  parameter int SW      = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  output revCascadePkg::strobeT strobe,
  output logic [SW-1:0]         stage,
  output logic                  busy,
  output logic                  done
);
  import revCascadePkg::*;

  typedef enum logic [1:0] {IDLE, EVAL, FOLDO, FOLDI} stateT;
  localparam logic [SW-1:0] LAST = SW'(N_GATES - 1);
  localparam logic [SW-1:0] FOLD_STAGE = SW'(N_GATES);

  stateT state;

  always_comb begin
    strobe.load    = (state == IDLE) && start;
    strobe.gate    = (state == EVAL);
    strobe.foldOut = (state == FOLDO);
    strobe.foldIn  = (state == FOLDI);
  end

  assign busy = (state != IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      stage <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        IDLE: if (start) begin
          state <= EVAL;
          stage <= '0;
        end
        EVAL: begin
          stage <= stage + 1'b1;
          if (stage == LAST) state <= FOLDO;
        end
        FOLDO: state <= FOLDI;
        FOLDI: begin
          state <= IDLE;
          done  <= 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5
  gate_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gate |-> stage < FOLD_STAGE);
  // R7
  fold_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.foldOut |-> stage == FOLD_STAGE);
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (stage != '0 || !strobe.gate || $past(strobe.foldIn)));
endmodule

// File: rtl/revDatapath.sv
module revDatapath #(
  parameter int P       = 4,
  parameter int Q       = 2,
  parameter int N_GATES = 4,
  parameter int TW      = 1,
  parameter int SW      = 3,
  parameter int LW      = 3,
  parameter logic [N_GATES*P-1:0]  CTRL_MASK = '0,
  parameter logic [N_GATES*P-1:0]  POL_MASK  = '1,
  parameter logic [N_GATES*TW-1:0] TGT       = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  revCascadePkg::strobeT strobe,
  input  logic [SW-1:0]         stage,
  input  logic [P-1:0]          inVec,
  input  logic                  faultEn,
  input  logic [SW-1:0]         faultStage,
  input  logic [LW-1:0]         faultLine,
  output logic [Q-1:0]          outVec,
  output logic                  errFlag
);
  localparam int LN  = P + Q + 1;
  localparam int CHK = P + Q;

  logic [LN-1:0] lines;
  logic          fEn;
  logic [SW-1:0] fStage;
  logic [LW-1:0] fLine;

  logic          injectNow;
  logic [LN-1:0] flipVec;
  logic [LN-1:0] afterFault;
  logic [LN-1:0] gFlip [N_GATES];
  logic [LN-1:0] gateFlip;
  logic          faultValid;

  assign faultValid = fEn && (fStage <= SW'(N_GATES)) && (fLine < LW'(LN));
  assign injectNow  = faultValid && (fStage == stage) && (strobe.gate || strobe.foldOut);
  assign flipVec    = injectNow ? (LN'(1) << fLine) : '0;
  assign afterFault = lines ^ flipVec;

  for (genvar g = 0; g < N_GATES; g++) begin : gGate
    logic [P-1:0]  mask, pol, sat;
    logic [TW-1:0] tgt;
    logic          fire;
    assign mask = CTRL_MASK[g*P +: P];
    assign pol  = POL_MASK[g*P +: P];
    assign tgt  = TGT[g*TW +: TW];
    assign sat  = ~(afterFault[P-1:0] ^ pol) | ~mask;
    assign fire = &sat;
    assign gFlip[g] = fire ? ((LN'(1) << (P + int'(tgt))) | (LN'(1) << CHK)) : '0;
  end

  always_comb begin
    gateFlip = '0;
    for (int g = 0; g < N_GATES; g++)
      if (stage == SW'(g)) gateFlip = gFlip[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lines   <= '0;
      fEn     <= 1'b0;
      fStage  <= '0;
      fLine   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        lines      <= '0;
        lines[P-1:0] <= inVec;
        lines[CHK] <= ^inVec;
        fEn        <= faultEn;
        fStage     <= faultStage;
        fLine      <= faultLine;
        errFlag    <= 1'b0;
      end else if (strobe.gate) begin
        lines <= afterFault ^ gateFlip;
      end else if (strobe.foldOut) begin
        lines      <= afterFault;
        lines[CHK] <= afterFault[CHK] ^ (^afterFault[P+Q-1:P]);
      end else if (strobe.foldIn) begin
        lines[CHK] <= lines[CHK] ^ (^lines[P-1:0]);
        errFlag    <= lines[CHK] ^ (^lines[P-1:0]);
      end
    end
  end

  assign outVec = lines[P+Q-1:P];

  // R4
  inputs_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gate && !injectNow) |=> lines[P-1:0] == $past(lines[P-1:0]));
  // R2
  clean_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.foldIn && !faultValid) |=> !errFlag);
  // R8
  fault_seen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.foldIn && faultValid) |=> errFlag);
  // R7
  one_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(flipVec) <= 1);
endmodule

// File: rtl/revCascadeTop.sv
module revCascadeTop #(
  parameter int P       = 4,
  parameter int Q       = 2,
  parameter int N_GATES = 4,
  parameter int TW      = (Q > 1) ? $clog2(Q) : 1,
  parameter int SW      = $clog2(N_GATES + 2),
  parameter int LW      = $clog2(P + Q + 2),
  parameter logic [N_GATES*P-1:0]  CTRL_MASK = {4'b1000, 4'b0110, 4'b0011, 4'b0001},
  parameter logic [N_GATES*P-1:0]  POL_MASK  = {4'b1111, 4'b1011, 4'b1111, 4'b1111},
  parameter logic [N_GATES*TW-1:0] TGT       = {1'b1, 1'b0, 1'b1, 1'b0}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [P-1:0]  inVec,
  input  logic          faultEn,
  input  logic [SW-1:0] faultStage,
  input  logic [LW-1:0] faultLine,
  output logic          busy,
  output logic          done,
  output logic [Q-1:0]  outVec,
  output logic          errFlag
);
  revCascadePkg::strobeT strobe;
  logic [SW-1:0] stage;

  revCtrl #(.N_GATES(N_GATES), .SW(SW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .stage(stage), .busy(busy), .done(done)
  );

  revDatapath #(
    .P(P), .Q(Q), .N_GATES(N_GATES), .TW(TW), .SW(SW), .LW(LW),
    .CTRL_MASK(CTRL_MASK), .POL_MASK(POL_MASK), .TGT(TGT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stage(stage),
    .inVec(inVec), .faultEn(faultEn), .faultStage(faultStage),
    .faultLine(faultLine), .outVec(outVec), .errFlag(errFlag)
  );
endmodule

// File: tb/revCascadeTop_tb.sv
module revCascadeTop_tb;
  localparam int P = 4, Q = 2, N = 4, TW = 1;
  localparam int SW = $clog2(N + 2), LW = $clog2(P + Q + 2);
  localparam int LN = P + Q + 1;
  localparam logic [N*P-1:0]  CM  = {4'b1000, 4'b0110, 4'b0011, 4'b0001};
  localparam logic [N*P-1:0]  PM  = {4'b1111, 4'b1011, 4'b1111, 4'b1111};
  localparam logic [N*TW-1:0] TG  = {1'b1, 1'b0, 1'b1, 1'b0};

  logic clk = 0, rstN = 0, start = 0, faultEn = 0;
  logic [P-1:0] inVec = '0;
  logic [SW-1:0] faultStage = '0;
  logic [LW-1:0] faultLine = '0;
  logic busy, done, errFlag;
  logic [Q-1:0] outVec;
  int nChk = 0, nBad = 0;

  always #2 clk = ~clk;

  revCascadeTop #(.P(P), .Q(Q), .N_GATES(N), .CTRL_MASK(CM), .POL_MASK(PM), .TGT(TG)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .inVec(inVec), .faultEn(faultEn),
    .faultStage(faultStage), .faultLine(faultLine), .busy(busy), .done(done),
    .outVec(outVec), .errFlag(errFlag));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference from the requirements: seeded check line, ordered gates, two folds.
  task automatic model(input logic [P-1:0] iv, input bit en, input int st, input int ln,
                       output logic [Q-1:0] o, output logic e);
    logic [LN-1:0] l;
    l = '0; l[P-1:0] = iv; l[P+Q] = ^iv;
    for (int g = 0; g < N; g++) begin
      bit fire;
      if (en && st == g && ln < LN) l[ln] = ~l[ln];
      fire = 1;
      for (int b = 0; b < P; b++)
        if (CM[g*P+b] && (l[b] != PM[g*P+b])) fire = 0;
      if (fire) begin
        l[P + int'(TG[g*TW +: TW])] ^= 1'b1;
        l[P+Q] ^= 1'b1;
      end
    end
    if (en && st == N && ln < LN) l[ln] = ~l[ln];
    o = l[P+Q-1:P];
    e = l[P+Q] ^ (^l[P+Q-1:P]) ^ (^l[P-1:0]);
  endtask

  task automatic run(input logic [P-1:0] iv, input bit en, input int st, input int ln,
                     output int cyc);
    @(negedge clk);
    inVec = iv; faultEn = en; faultStage = SW'(st); faultLine = LW'(ln); start = 1;
    @(posedge clk);
    @(negedge clk);
    start = 0; cyc = 0;
    while (!done && cyc < 50) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
  endtask

  task automatic runCheck(input logic [P-1:0] iv, input bit en, input int st, input int ln,
                          input string req);
    logic [Q-1:0] eo; logic ee; int cyc;
    model(iv, en, st, ln, eo, ee);
    run(iv, en, st, ln, cyc);
    check(outVec == eo, {req, " outVec"}, outVec, eo);
    check(errFlag == ee, {req, " errFlag"}, errFlag, ee);
  endtask

  task automatic testReset();
    check(!busy && !done && !errFlag && outVec == '0, "R1 reset", {busy, done, errFlag, outVec}, 0);
  endtask

  task automatic testCleanSweep();
    for (int v = 0; v < (1 << P); v++) runCheck(P'(v), 0, 0, 0, "R2 R3 clean");
  endtask

  task automatic testTiming();
    int cyc;
    run(4'b0101, 0, 0, 0, cyc);
    check(cyc == N + 2, "R5 latency", cyc, N + 2);
    @(negedge clk);
    check(!done && !busy, "R5 done one cycle", {done, busy}, 0);
  endtask

  task automatic testBusyStart();
    logic [Q-1:0] eo; logic ee; int cyc;
    model(4'b0011, 0, 0, 0, eo, ee);
    @(negedge clk);
    inVec = 4'b0011; faultEn = 0; start = 1;
    @(posedge clk); @(negedge clk);
    check(busy, "R5 busy", busy, 1);
    inVec = 4'b1100; faultEn = 1; faultStage = '0; faultLine = '0; start = 1;
    cyc = 0;
    while (!done && cyc < 50) begin
      @(posedge clk); cyc++; @(negedge clk);
      start = 0;
    end
    check(cyc == N + 2, "R6 timing", cyc, N + 2);
    check(outVec == eo && errFlag == ee, "R6 ignored start", {outVec, errFlag}, {eo, ee});
  endtask

  task automatic testSpreadCase();
    logic [Q-1:0] cleanO, eo; logic ee;
    model(4'b0010, 0, 0, 0, cleanO, ee);
    runCheck(4'b0010, 1, 0, 0, "R8 spread");
    model(4'b0010, 1, 0, 0, eo, ee);
    check((eo ^ cleanO) == 2'b11, "R8 spread reaches both outputs", eo ^ cleanO, 3);
    check(errFlag == 1'b1, "R8 spread flag", errFlag, 1);
  endtask

  task automatic testFaultSweep();
    logic [P-1:0] vecs [3] = '{4'b0010, 4'b1011, 4'b0110};
    foreach (vecs[i])
      for (int st = 0; st <= N; st++)
        for (int ln = 0; ln < LN; ln++) begin
          runCheck(vecs[i], 1, st, ln, "R7 R8 sweep");
          check(errFlag == 1'b1, "R8 detect", errFlag, 1);
        end
  endtask

  task automatic testCheckLine();
    for (int st = 0; st <= N; st++) begin
      runCheck(4'b1001, 1, st, P + Q, "R9 check line");
      check(errFlag == 1'b1, "R9 flag", errFlag, 1);
    end
  endtask

  task automatic testOutOfRange();
    runCheck(4'b0111, 1, N + 1, 0, "R10 stage");
    check(errFlag == 1'b0, "R10 stage flag", errFlag, 0);
    runCheck(4'b0111, 1, 0, LN, "R10 line");
    check(errFlag == 1'b0, "R10 line flag", errFlag, 0);
  endtask

  task automatic testHold();
    logic [Q-1:0] o; logic e;
    runCheck(4'b0010, 1, 1, P, "R11 setup");
    o = outVec; e = errFlag;
    inVec = 4'b1111;
    repeat (5) @(negedge clk);
    check(outVec == o && errFlag == e, "R11 hold", {outVec, errFlag}, {o, e});
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        testReset();
        rstN = 1;
        repeat (2) @(negedge clk);
        testReset();
        testCleanSweep();
        testTiming();
        testBusyStart();
        testSpreadCase();
        testFaultSweep();
        testCheckLine();
        testOutOfRange();
        testHold();
      end
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule